// File: doc/BRIEF.md
# Byte-Addressable Little-Endian Data Memory

This block is the data store of a 32-bit processor. It takes a 16-bit byte address, a read strobe, a write strobe and a size select that picks a full-word or a single-byte access. Words are kept least-significant byte first. A byte load comes back zero-extended to 32 bits. Read data is registered and appears on the clock after the read strobe. A word access whose address is not on a four-byte boundary is refused. The refusal shows on a fault output in the same cycle as the strobe, and the stored bytes are left untouched.

The storage is split into one byte-wide bank per lane. The two low address bits pick a lane and the rest pick a row. The address space is 64 KB. The number of bytes actually backed is set by the parameter `BACKED_AW`, which defaults to 12 (4 KB). Set it to 16 to back the whole space. A testbench fills the memory through the ordinary write port.

Top module: `dmem_le_top`

## Requirements
- R1: The byte address is 16 bits wide (64 KB space). Only the low `BACKED_AW` bits select storage (default 12), so with the default, byte addresses 0x1200 and 0x0200 reach the same location, and so do 0xFFFF and 0x0FFF.
- R2: A word read (`size_word`=1) at address A returns byte A on bits [7:0], A+1 on [15:8], A+2 on [23:16] and A+3 on [31:24].
- R3: `align_fault` is high, combinationally in the cycle of the strobe, exactly when `rd_en` or `wr_en` is high, `size_word`=1 and `addr[1:0]` is not 00. With both strobes low it stays low.
- R4: A faulting store changes no byte of memory.
- R5: A byte store (`size_word`=0) writes `wdata[7:0]` into the single addressed byte and leaves the other three bytes of that word unchanged.
- R6: A word store writes `wdata[7:0]` to A, `[15:8]` to A+1, `[23:16]` to A+2 and `[31:24]` to A+3, the same order used for reads.
- R7: A byte load returns the addressed byte on bits [7:0] with bits [31:8] zero.
- R8: `rdata` changes only on the clock edge that samples `rd_en` high. It is valid from that edge on and holds its value while no read is issued.
- R9: A byte access never raises `align_fault`, whatever the value of `addr[1:0]`.
- R10: A faulting read returns 0 on `rdata`.
- R11: During and after reset, before any read, `rdata` is 0. `align_fault` is 0 while no strobe is active.
- R12: When a read and a write hit the same address in the same cycle, the read returns the contents from before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read path |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| size_word | input | 1 | Access size: 1 = 32-bit word, 0 = single byte |
| addr | input | 16 | Byte address |
| wdata | input | 32 | Store data; a byte store uses bits [7:0] |
| rdata | output | 32 | Load data, registered, valid the cycle after `rd_en` |
| align_fault | output | 1 | Misaligned word access refused (combinational) |

## Verification
The hardest case to provoke is a refused store. It has no visible effect, so it can only be observed by re-reading the word it would have clobbered. The bench first loads a known word, then issues an all-ones word store at an offset inside it, and then reads the aligned word back to show the pattern has not changed. Lane isolation gets the same treatment: a byte store is followed by a full-word read, so any spill into a neighbouring lane shows in the upper bytes. Aliasing above the backed range is reached by writing at a high address and reading at its folded low twin. A combined read-and-write cycle shows that the old data is returned.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

   typedef enum logic {
      ACC_BYTE = 1'b0,
      ACC_WORD = 1'b1
   } acc_size_e;

   function automatic int lane_bits(input int data_w);
      return $clog2(data_w / 8);
   endfunction

endpackage

// File: rtl/dmem_align_chk.sv
module dmem_align_chk
   import dmem_pkg::*;
#(
   parameter int LANE_AW = 2
) (
   input  logic               rd_en,
   input  logic               wr_en,
   input  acc_size_e          size,
   input  logic [LANE_AW-1:0] low_addr,
   output logic               fault,
   output logic               rd_ok,
   output logic               wr_ok
);

   logic strobe;
   logic misaligned;

   always_comb begin
      strobe     = rd_en | wr_en;
      misaligned = (size == ACC_WORD) && (low_addr != '0);
      fault      = strobe & misaligned;
      rd_ok      = rd_en & ~misaligned;
      wr_ok      = wr_en & ~misaligned;
   end

endmodule

// File: rtl/dmem_lane_sel.sv
module dmem_lane_sel
   import dmem_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int LANES   = DATA_W / 8,
   parameter int LANE_AW = 2
) (
   input  logic               wr_ok,
   input  acc_size_e          size,
   input  logic [LANE_AW-1:0] lane,
   input  logic [DATA_W-1:0]  wdata,
   output logic [LANES-1:0]   lane_we,
   output logic [DATA_W-1:0]  lane_wd
);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic hit;
      always_comb begin
         hit = (size == ACC_WORD) || (lane == LANE_AW'(k));
         lane_we[k] = wr_ok & hit;
         if (size == ACC_WORD) begin
            lane_wd[k*8 +: 8] = wdata[k*8 +: 8];
         end else begin
            lane_wd[k*8 +: 8] = wdata[7:0];
         end
      end
   end

endmodule

// File: rtl/dmem_lane_bank.sv
module dmem_lane_bank #(
   parameter int ROW_AW = 10,
   localparam int ROWS  = 1 << ROW_AW
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [ROW_AW-1:0] row,
   input  logic [7:0]        wbyte,
   output logic [7:0]        rbyte
);

   logic [7:0] cells [ROWS];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[row] <= wbyte;
      end
   end

   always_ff @(posedge clk) begin
      if (re) begin
         rbyte <= cells[row];
      end
   end

endmodule

// File: rtl/dmem_rd_fmt.sv
module dmem_rd_fmt
   import dmem_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int LANE_AW = 2
) (
   input  logic               live,
   input  acc_size_e          size,
   input  logic [LANE_AW-1:0] lane,
   input  logic [DATA_W-1:0]  raw,
   output logic [DATA_W-1:0]  rdata
);

   logic [7:0] picked;

   always_comb begin
      picked = raw[lane*8 +: 8];
      if (!live) begin
         rdata = '0;
      end else if (size == ACC_WORD) begin
         rdata = raw;
      end else begin
         rdata = {{(DATA_W-8){1'b0}}, picked};
      end
   end

endmodule

// File: rtl/dmem_le_top.sv
module dmem_le_top
   import dmem_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int BACKED_AW = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic              size_word,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              align_fault
);

   localparam int LANES   = DATA_W / 8;
   localparam int LANE_AW = lane_bits(DATA_W);
   localparam int ROW_AW  = BACKED_AW - LANE_AW;

   if (DATA_W % 8 != 0 || (1 << LANE_AW) != LANES || LANES < 2) begin : g_bad_width
      $error("dmem_le_top: DATA_W must be a power-of-two multiple of 8");
   end
   if (BACKED_AW > ADDR_W || BACKED_AW <= LANE_AW) begin : g_bad_backed
      $error("dmem_le_top: BACKED_AW out of range");
   end

   acc_size_e          size;
   logic [LANE_AW-1:0] lane;
   logic [ROW_AW-1:0]  row;
   logic               rd_ok;
   logic               wr_ok;
   logic [LANES-1:0]   lane_we;
   logic [DATA_W-1:0]  lane_wd;
   logic [DATA_W-1:0]  raw_q;

   logic               live_q;
   acc_size_e          size_q;
   logic [LANE_AW-1:0] lane_q;

   always_comb begin
      size = acc_size_e'(size_word);
      lane = addr[LANE_AW-1:0];
      row  = addr[BACKED_AW-1:LANE_AW];
   end

   dmem_align_chk #(.LANE_AW(LANE_AW)) u_align (
      .rd_en    (rd_en),
      .wr_en    (wr_en),
      .size     (size),
      .low_addr (lane),
      .fault    (align_fault),
      .rd_ok    (rd_ok),
      .wr_ok    (wr_ok)
   );

   dmem_lane_sel #(.DATA_W(DATA_W), .LANES(LANES), .LANE_AW(LANE_AW)) u_sel (
      .wr_ok   (wr_ok),
      .size    (size),
      .lane    (lane),
      .wdata   (wdata),
      .lane_we (lane_we),
      .lane_wd (lane_wd)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_bank
      dmem_lane_bank #(.ROW_AW(ROW_AW)) u_bank (
         .clk   (clk),
         .we    (lane_we[k]),
         .re    (rd_ok),
         .row   (row),
         .wbyte (lane_wd[k*8 +: 8]),
         .rbyte (raw_q[k*8 +: 8])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         size_q <= ACC_BYTE;
         lane_q <= '0;
      end else if (rd_en) begin
         live_q <= rd_ok;
         size_q <= size;
         lane_q <= lane;
      end
   end

   dmem_rd_fmt #(.DATA_W(DATA_W), .LANE_AW(LANE_AW)) u_fmt (
      .live  (live_q),
      .size  (size_q),
      .lane  (lane_q),
      .raw   (raw_q),
      .rdata (rdata)
   );

endmodule

// File: rtl/dmem_le_chk.sv
module dmem_le_chk #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int LANE_AW = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              wr_en,
   input logic              size_word,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] rdata,
   input logic              align_fault
);

   p_misaligned_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_en || wr_en) && size_word && addr[LANE_AW-1:0] != '0) |-> align_fault);

   p_idle_no_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && !wr_en) |-> !align_fault);

   p_byte_no_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !size_word |-> !align_fault);

   p_zero_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !size_word) |=> (rdata[DATA_W-1:8] == '0));

   p_fault_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && align_fault) |=> (rdata == '0));

   p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

endmodule

bind dmem_le_top dmem_le_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .LANE_AW (LANE_AW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_en       (rd_en),
   .wr_en       (wr_en),
   .size_word   (size_word),
   .addr        (addr),
   .rdata       (rdata),
   .align_fault (align_fault)
);

// File: tb/dmem_le_top_tb_top.sv
module dmem_le_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   typedef struct packed {
      logic        wr;
      logic        rd;
      logic        wsz;
      logic [15:0] a;
      logic [31:0] d;
      logic [31:0] exp;
      logic        expf;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 1'b1, 16'h0100, 32'h44332211, 32'h0,        1'b0, 4'd6 },  // R6
      '{1'b0, 1'b1, 1'b1, 16'h0100, 32'h0,        32'h44332211, 1'b0, 4'd2 },  // R2
      '{1'b0, 1'b1, 1'b0, 16'h0100, 32'h0,        32'h00000011, 1'b0, 4'd7 },  // R7
      '{1'b0, 1'b1, 1'b0, 16'h0103, 32'h0,        32'h00000044, 1'b0, 4'd7 },  // R7
      '{1'b1, 1'b0, 1'b0, 16'h0102, 32'hAABBCCEE, 32'h0,        1'b0, 4'd5 },  // R5
      '{1'b0, 1'b1, 1'b1, 16'h0100, 32'h0,        32'h44EE2211, 1'b0, 4'd5 },  // R5
      '{1'b1, 1'b0, 1'b1, 16'h0101, 32'hFFFFFFFF, 32'h0,        1'b1, 4'd3 },  // R3
      '{1'b0, 1'b1, 1'b1, 16'h0100, 32'h0,        32'h44EE2211, 1'b0, 4'd4 },  // R4
      '{1'b1, 1'b0, 1'b1, 16'h0103, 32'hFFFFFFFF, 32'h0,        1'b1, 4'd3 },  // R3
      '{1'b0, 1'b1, 1'b1, 16'h0104, 32'h0,        32'h0,        1'b0, 4'd4 },  // R4 (word 0x104 stored below first)
      '{1'b0, 1'b1, 1'b1, 16'h0102, 32'h0,        32'h0,        1'b1, 4'd10},  // R10
      '{1'b0, 1'b1, 1'b0, 16'h0101, 32'h0,        32'h00000022, 1'b0, 4'd9 },  // R9
      '{1'b1, 1'b0, 1'b1, 16'h1200, 32'h80706050, 32'h0,        1'b0, 4'd1 },  // R1
      '{1'b0, 1'b1, 1'b1, 16'h0200, 32'h0,        32'h80706050, 1'b0, 4'd1 },  // R1
      '{1'b1, 1'b0, 1'b0, 16'hFFFF, 32'h0000005A, 32'h0,        1'b0, 4'd1 },  // R1
      '{1'b1, 1'b1, 1'b1, 16'h0200, 32'h01020304, 32'h80706050, 1'b0, 4'd12},  // R12
      '{1'b0, 1'b1, 1'b1, 16'h0200, 32'h0,        32'h01020304, 1'b0, 4'd12}   // R12
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        rd_en;
   logic        wr_en;
   logic        size_word;
   logic [15:0] addr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        align_fault;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dmem_le_top dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_en       (rd_en),
      .wr_en       (wr_en),
      .size_word   (size_word),
      .addr        (addr),
      .wdata       (wdata),
      .rdata       (rdata),
      .align_fault (align_fault)
   );

   task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic op(input logic wr, input logic rd, input logic wsz,
                     input logic [15:0] a, input logic [31:0] d,
                     output logic flt, output logic [31:0] q);
      @(negedge clk);
      wr_en = wr; rd_en = rd; size_word = wsz; addr = a; wdata = d;
      #1 flt = align_fault;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      q = rdata;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic        f;
      logic [31:0] q;
      logic [31:0] held;
      rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; size_word = 1'b0;
      addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      check32("R11 rdata in reset", rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check32("R11 rdata after reset", rdata, 32'h0);
      check32("R11 fault idle", {31'b0, align_fault}, 32'h0);

      // preload word 0x104 for the R4 row that follows the misaligned store at 0x103
      op(1'b1, 1'b0, 1'b1, 16'h0104, 32'h00000000, f, q);

      for (int i = 0; i < NV; i++) begin
         op(VECS[i].wr, VECS[i].rd, VECS[i].wsz, VECS[i].a, VECS[i].d, f, q);
         check32($sformatf("R%0d vec%0d fault", VECS[i].req, i), {31'b0, f}, {31'b0, VECS[i].expf});
         if (VECS[i].rd) begin
            check32($sformatf("R%0d vec%0d rdata", VECS[i].req, i), q, VECS[i].exp);
         end
      end

      // R1: byte at 0xFFFF folds onto 0x0FFF
      op(1'b0, 1'b1, 1'b0, 16'h0FFF, 32'h0, f, q);
      check32("R1 alias byte 0x0FFF", q, 32'h0000005A);

      // R3: misaligned word settings with no strobe raise nothing
      @(negedge clk);
      size_word = 1'b1; addr = 16'h0102;
      #1 check32("R3 no strobe no fault", {31'b0, align_fault}, 32'h0);

      // R8: data held while idle, changes only at the read edge
      op(1'b0, 1'b1, 1'b1, 16'h0100, 32'h0, f, q);
      held = rdata;
      check32("R8 read valid next cycle", held, 32'h44EE2211);
      op(1'b1, 1'b0, 1'b1, 16'h0100, 32'h12345678, f, q);
      repeat (3) @(negedge clk);
      check32("R8 rdata held without read", rdata, held);
      op(1'b0, 1'b1, 1'b1, 16'h0100, 32'h0, f, q);
      check32("R8 new read updates", q, 32'h12345678);

      // R9: byte accesses at every offset never fault
      for (int k = 0; k < 4; k++) begin
         op(1'b0, 1'b1, 1'b0, 16'h0100 + 16'(k), 32'h0, f, q);
         check32("R9 byte no fault", {31'b0, f}, 32'h0);
         check32("R7 byte lane zext", q, {24'h0, 8'(32'h12345678 >> (8*k))});
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule